// File: doc/BRIEF.md
# Microcode Step Sequencer with Flag Branching

This block is the control heart of a small microcoded processor. It holds the opcode of the instruction being executed and a 3-bit micro-step index. Together with an interrupt-active bit they form the address of the microcode store. Every clock the microword returned from that store tells the sequencer what to do next. It can fetch a fresh opcode from the memory data bus, which restarts the step index at zero. It can instead move to a step chosen by three next-step bits, and bit 0 of that step can be forced high by flag conditions, which gives the microcode a two-way branch.

A holding register can capture an opcode ahead of time, so that a final write step overlaps the fetch of the next instruction. A run flag and an interrupt-active flag gate the whole sequencer. While both are clear the block stalls: it ignores every control input, and only the external interrupt request can wake it. The microcode store and the datapath sit outside this block.

Top module: `useq_top`

## Requirements
- R1: After asynchronous reset (rstN low): opcode is 0x00, step index is 0, the run flag is 1, the interrupt-active flag is 0, and the held prefetch opcode is 0x00.
- R2: uAddr is combinational. Bit 11 holds the interrupt-active flag, bits 10:3 hold the opcode and bits 2:0 hold the step index.
- R3: When enabled, ctlLoadOp loads the opcode at the next edge and clears the step index to 0. With ctlUsePre low the opcode comes from memData. ctlLoadOp takes priority over ctlLoadStep.
- R4: When enabled, ctlLoadStep (without ctlLoadOp) loads the step index from ctlNext. Bit 0 of the loaded index is ctlNext[0] ORed with the condition hit.
- R5: The condition hit is the OR of the enabled conditions in ctlCondEn: bit 0 means zero flag clear, bit 1 means zero flag set, bit 2 means carry clear, and bit 3 means carry set. Any number of enables may be active at once.
- R6: When enabled, ctlPrefetch copies memData into the holding register. A later ctlLoadOp with ctlUsePre high takes the opcode from the holding register instead of from memData.
- R7: When enabled, ctlRunClk loads the run flag from ctlRunVal at the next edge.
- R8: irqIn sets the interrupt-active flag at the next edge, whether or not the sequencer is enabled, and it wins over ctlIntClk. Otherwise, when enabled, ctlIntClk loads the flag from ctlIntVal.
- R9: While the run flag and the interrupt-active flag are both 0, ctlLoadOp, ctlLoadStep, ctlPrefetch, ctlRunClk and ctlIntClk have no effect. Opcode, step, holding register and run flag keep their values.
- R10: stepEn is high exactly when the run flag or the interrupt-active flag is high. "Enabled" in R3 to R8 means stepEn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memData | input | 8 | Memory data bus carrying fetched opcodes |
| ctlLoadOp | input | 1 | Load a new opcode and restart at step 0 |
| ctlUsePre | input | 1 | Take the new opcode from the holding register |
| ctlPrefetch | input | 1 | Capture memData into the holding register |
| ctlLoadStep | input | 1 | Load the step index from ctlNext |
| ctlNext | input | 3 | Next micro-step index |
| ctlCondEn | input | 4 | Condition enables: NZ, Z, NC, C (bits 0 to 3) |
| flagZero | input | 1 | Zero flag from the datapath |
| flagCarry | input | 1 | Carry flag from the datapath |
| ctlRunClk | input | 1 | Update the run flag |
| ctlRunVal | input | 1 | New run flag value |
| ctlIntClk | input | 1 | Update the interrupt-active flag |
| ctlIntVal | input | 1 | New interrupt-active value |
| irqIn | input | 1 | External interrupt request; sets interrupt-active |
| uAddr | output | 12 | Microcode address {int, opcode, step} |
| opcode | output | 8 | Current opcode |
| stepIdx | output | 3 | Current micro-step |
| runFlag | output | 1 | Run flag |
| intActive | output | 1 | Interrupt-active flag |
| stepEn | output | 1 | Sequencer enabled (run or interrupt active) |

## Verification
The assertions take for granted that every control and flag input holds a clean 0 or 1 at each rising edge. They also assume that reset is applied before the first edge, since the checks relating a strobe to the next step index or opcode are disabled while rstN is low. The bench changes inputs only on the falling edge and clears every control between operations, so no stray strobe reaches an edge. Branching is swept over all 16 enable patterns, both flag values and all 8 next-step values, and the opcode load path is swept over all 256 memory values.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int COND_N = 4;

  // condition enable positions (decoded by microcode bits)
  localparam int COND_NZ = 0;
  localparam int COND_Z  = 1;
  localparam int COND_NC = 2;
  localparam int COND_C  = 3;

  typedef struct packed {
    logic opLoad;
    logic opFromPre;
    logic preLoad;
    logic stepLoad;
    logic forceBit0;
  } seqStrb_t;
endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlLoadOp,
  input  logic              ctlUsePre,
  input  logic              ctlPrefetch,
  input  logic              ctlLoadStep,
  input  logic [COND_N-1:0] ctlCondEn,
  input  logic              flagZero,
  input  logic              flagCarry,
  input  logic              ctlRunClk,
  input  logic              ctlRunVal,
  input  logic              ctlIntClk,
  input  logic              ctlIntVal,
  input  logic              irqIn,
  output seqStrb_t          strb,
  output logic              runFlag,
  output logic              intActive,
  output logic              stepEn
);
  logic [COND_N-1:0] condTrue;
  logic              condHit;

  // each enable watches one flag in one polarity: even = flag clear, odd = flag set
  for (genvar i = 0; i < COND_N; i++) begin : g_cond
    localparam bit ON_CARRY = (i / 2) == 1;
    localparam bit WANT_SET = (i % 2) == 1;
    assign condTrue[i] = ((ON_CARRY ? flagCarry : flagZero) == WANT_SET);
  end

  assign condHit = |(condTrue & ctlCondEn);
  assign stepEn  = runFlag | intActive;

  always_comb begin
    strb.opLoad    = stepEn & ctlLoadOp;
    strb.opFromPre = ctlUsePre;
    strb.preLoad   = stepEn & ctlPrefetch;
    strb.stepLoad  = stepEn & ctlLoadStep;
    strb.forceBit0 = condHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runFlag   <= 1'b1;
      intActive <= 1'b0;
    end else begin
      if (stepEn && ctlRunClk) runFlag <= ctlRunVal;
      if (irqIn) intActive <= 1'b1;
      else if (stepEn && ctlIntClk) intActive <= ctlIntVal;
    end
  end

  // R8
  irq_sets_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqIn |=> intActive);

  // R7
  run_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && ctlRunClk) |=> (runFlag == $past(ctlRunVal)));

  // R9
  halt_run_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stepEn |=> $stable(runFlag));

  // R10
  stalled_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stepEn |-> !(strb.opLoad || strb.stepLoad || strb.preLoad));
endmodule

// File: rtl/useq_dp.sv
module useq_dp
  import useq_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int STEP_W = 3,
  localparam int ADDR_W = 1 + OP_W + STEP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic [OP_W-1:0]   memData,
  input  logic [STEP_W-1:0] stepNext,
  input  logic              intActive,
  output logic [OP_W-1:0]   opcode,
  output logic [STEP_W-1:0] stepIdx,
  output logic [ADDR_W-1:0] uAddr
);
  logic [OP_W-1:0] preOp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcode  <= '0;
      stepIdx <= '0;
      preOp   <= '0;
    end else begin
      if (strb.preLoad) preOp <= memData;
      if (strb.opLoad) begin
        opcode  <= strb.opFromPre ? preOp : memData;
        stepIdx <= '0;
      end else if (strb.stepLoad) begin
        stepIdx <= {stepNext[STEP_W-1:1], stepNext[0] | strb.forceBit0};
      end
    end
  end

  assign uAddr = {intActive, opcode, stepIdx};

  // R3
  load_clears_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.opLoad |=> (stepIdx == '0));

  // R3
  opcode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.opLoad |=> $stable(opcode));

  // R4
  step_upper_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepLoad && !strb.opLoad) |=>
      (stepIdx[STEP_W-1:1] == $past(stepNext[STEP_W-1:1])));

  // R5
  force_bit0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepLoad && !strb.opLoad && strb.forceBit0) |=> stepIdx[0]);
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int STEP_W = 3,
  localparam int ADDR_W = 1 + OP_W + STEP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   memData,
  input  logic              ctlLoadOp,
  input  logic              ctlUsePre,
  input  logic              ctlPrefetch,
  input  logic              ctlLoadStep,
  input  logic [STEP_W-1:0] ctlNext,
  input  logic [COND_N-1:0] ctlCondEn,
  input  logic              flagZero,
  input  logic              flagCarry,
  input  logic              ctlRunClk,
  input  logic              ctlRunVal,
  input  logic              ctlIntClk,
  input  logic              ctlIntVal,
  input  logic              irqIn,
  output logic [ADDR_W-1:0] uAddr,
  output logic [OP_W-1:0]   opcode,
  output logic [STEP_W-1:0] stepIdx,
  output logic              runFlag,
  output logic              intActive,
  output logic              stepEn
);
  seqStrb_t strb;

  useq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .ctlLoadOp(ctlLoadOp), .ctlUsePre(ctlUsePre), .ctlPrefetch(ctlPrefetch),
    .ctlLoadStep(ctlLoadStep), .ctlCondEn(ctlCondEn),
    .flagZero(flagZero), .flagCarry(flagCarry),
    .ctlRunClk(ctlRunClk), .ctlRunVal(ctlRunVal),
    .ctlIntClk(ctlIntClk), .ctlIntVal(ctlIntVal), .irqIn(irqIn),
    .strb(strb), .runFlag(runFlag), .intActive(intActive), .stepEn(stepEn)
  );

  useq_dp #(.OP_W(OP_W), .STEP_W(STEP_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .memData(memData),
    .stepNext(ctlNext), .intActive(intActive),
    .opcode(opcode), .stepIdx(stepIdx), .uAddr(uAddr)
  );
endmodule

// File: tb/useq_top_tb_top.sv
`timescale 1ns/1ps
module useq_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] memData;
  logic ctlLoadOp, ctlUsePre, ctlPrefetch, ctlLoadStep;
  logic [2:0] ctlNext;
  logic [3:0] ctlCondEn;
  logic flagZero, flagCarry, ctlRunClk, ctlRunVal, ctlIntClk, ctlIntVal, irqIn;
  logic [11:0] uAddr;
  logic [7:0] opcode;
  logic [2:0] stepIdx;
  logic runFlag, intActive, stepEn;

  int nTests = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  useq_top dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearCtl();
    ctlLoadOp = 0; ctlUsePre = 0; ctlPrefetch = 0; ctlLoadStep = 0;
    ctlNext = 0; ctlCondEn = 0; ctlRunClk = 0; ctlRunVal = 0;
    ctlIntClk = 0; ctlIntVal = 0; irqIn = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    clearCtl();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] heldOp;
    clearCtl();
    memData = 0; flagZero = 0; flagCarry = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 enable
    chk("R1 opcode", opcode, 8'h00);
    chk("R1 step", stepIdx, 3'd0);
    chk("R1 run", runFlag, 1'b1);
    chk("R1 int", intActive, 1'b0);
    chk("R2 uAddr reset", uAddr, 12'h000);
    chk("R10 stepEn reset", stepEn, 1'b1);

    // R3 opcode load over all values, R2 address packing
    for (int v = 0; v < 256; v++) begin
      ctlLoadStep = 1; ctlNext = 3'd5;
      tick();
      memData = v[7:0]; ctlLoadOp = 1;
      tick();
      chk("R3 opcode", opcode, v[7:0]);
      chk("R3 step cleared", stepIdx, 3'd0);
      chk("R2 uAddr", uAddr, {1'b0, v[7:0], 3'd0});
    end

    // R3 priority of opcode load over step load
    memData = 8'h42; ctlLoadOp = 1; ctlLoadStep = 1; ctlNext = 3'd7;
    tick();
    chk("R3 priority step", stepIdx, 3'd0);
    chk("R3 priority op", opcode, 8'h42);

    // R4/R5 exhaustive branch sweep
    for (int en = 0; en < 16; en++)
      for (int fz = 0; fz < 2; fz++)
        for (int fc = 0; fc < 2; fc++)
          for (int nx = 0; nx < 8; nx++) begin
            logic hit;
            hit = (en[0] && fz == 0) || (en[1] && fz == 1) ||
                  (en[2] && fc == 0) || (en[3] && fc == 1);
            ctlLoadStep = 1; ctlNext = nx[2:0]; ctlCondEn = en[3:0];
            flagZero = fz[0]; flagCarry = fc[0];
            tick();
            chk("R4 R5 branch step", stepIdx, {nx[2:1], nx[0] | hit});
          end
    flagZero = 0; flagCarry = 0;

    // R6 prefetch then load from holding register
    memData = 8'h3C; ctlPrefetch = 1;
    tick();
    chk("R6 opcode untouched by prefetch", opcode, 8'h42);
    memData = 8'h99; ctlLoadOp = 1; ctlUsePre = 1;
    tick();
    chk("R6 opcode from holding reg", opcode, 8'h3C);
    heldOp = 8'h3C;

    // R7 run flag clear, R10 stall
    ctlLoadStep = 1; ctlNext = 3'd2;
    tick();
    ctlRunClk = 1; ctlRunVal = 0;
    tick();
    chk("R7 run cleared", runFlag, 1'b0);
    chk("R10 stepEn low", stepEn, 1'b0);

    // R9 everything ignored while stalled
    memData = 8'h55; ctlLoadOp = 1; ctlLoadStep = 1; ctlNext = 3'd6;
    ctlPrefetch = 1; ctlRunClk = 1; ctlRunVal = 1; ctlIntClk = 1; ctlIntVal = 1;
    tick();
    chk("R9 opcode held", opcode, heldOp);
    chk("R9 step held", stepIdx, 3'd2);
    chk("R9 run held", runFlag, 1'b0);
    chk("R9 int held", intActive, 1'b0);

    // R8 interrupt request wakes the sequencer
    irqIn = 1;
    tick();
    chk("R8 irq sets int", intActive, 1'b1);
    chk("R10 stepEn via int", stepEn, 1'b1);
    chk("R2 uAddr int bit", uAddr, {1'b1, heldOp, 3'd2});

    // R9 holding register was not overwritten during the stall
    memData = 8'hE1; ctlLoadOp = 1; ctlUsePre = 1;
    tick();
    chk("R9 holding reg kept", opcode, heldOp);

    // R8 irq wins over clear
    irqIn = 1; ctlIntClk = 1; ctlIntVal = 0;
    tick();
    chk("R8 irq priority", intActive, 1'b1);

    // R8 clear via control -> stall again (run is 0)
    ctlIntClk = 1; ctlIntVal = 0;
    tick();
    chk("R8 int cleared", intActive, 1'b0);
    chk("R10 stall after return", stepEn, 1'b0);

    // wake, restore run, then return from interrupt
    irqIn = 1;
    tick();
    ctlRunClk = 1; ctlRunVal = 1;
    tick();
    chk("R7 run set", runFlag, 1'b1);
    ctlIntClk = 1; ctlIntVal = 0;
    tick();
    chk("R8 int cleared running", intActive, 1'b0);
    chk("R10 stepEn by run", stepEn, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule